// File: doc/BRIEF.md
# Configurable 1-0-1 Serial Pattern Detector

This block samples a one-bit serial stream on every rising clock edge. It pulses a one-bit detect flag each time the bits 1, 0, 1 arrive in that order. Two static mode inputs shape its behaviour, so one detector covers all four variants.

The first mode input sets the overlap rule. In overlapping mode, the closing 1 of a match may also open the next match. In non-overlapping mode, bits already used by a match are discarded. The second mode input sets the output style. In Mealy style, the flag is decoded from the current state together with the incoming bit, so it is raised in the same cycle as the closing 1. In Moore style, the flag is decoded from a dedicated hit state alone. It therefore appears one cycle later and is free of input-driven glitches.

An asynchronous active-low reset clears the machine at once. Its release is synchronised to the clock, so the machine leaves idle only after a fixed number of rising edges.

Top module: `pat101_detector`

## Requirements
- R1: The detect flag `hit_o` is 1 only for a completed 1-0-1 sequence (oldest bit first) and 0 in every other cycle. It is never 1 in two consecutive cycles.
- R2: With `moore_sel_i`=0 (Mealy style), `hit_o` is 1 during the same clock cycle in which the closing 1 is present on `bit_i`.
- R3: With `moore_sel_i`=1 (Moore style), `hit_o` is 1 for exactly one cycle. That cycle is the one after the closing 1 was sampled, and the value is taken from the state register only.
- R4: With `overlap_i`=1, the stream 0110101011001 yields, bit for bit, the Mealy flag sequence 0000101010000. The Moore flag sequence is the same, one cycle later.
- R5: With `overlap_i`=0, the same stream yields the Mealy flag sequence 0000100010000. The Moore flag sequence is the same, one cycle later.
- R6: While `rst_n_i` is 0, the machine is idle and `hit_o` is 0, whatever `bit_i` is. After `rst_n_i` rises, the machine starts sampling once `SYNC_STAGES` rising edges have passed.
- R7: A repeated 1 keeps a partial match alive. Stream 1101 from idle raises the flag on its fourth bit.
- R8: A 0 after a received 1-0 abandons the partial match. Stream 1001 from idle never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; release synchronised inside |
| bit_i | input | 1 | Serial data bit, one per clock |
| overlap_i | input | 1 | 1 = overlapping detection, 0 = non-overlapping; static out of reset |
| moore_sel_i | input | 1 | 1 = Moore-style flag, 0 = Mealy-style flag; static out of reset |
| hit_o | output | 1 | Detect flag |

## Verification
A Mealy flag belongs to the same clock window as the bit that completes the pattern. A Moore flag belongs to the window after it, because the hit state is written at the edge that samples the closing bit. The driver stamps every expected flag with its due cycle: the current window in Mealy style, the next one in Moore style. The monitor samples shortly before each rising edge and compares only the entries whose stamp matches the current cycle. Expected values come either from the fixed 13-bit example strings or from a sliding three-bit window model. That model has a spacing counter for the non-overlapping rule.

// File: rtl/pat101_pkg.sv
package pat101_pkg;

  // Ordered match progress; the hit code is only reached in Moore style.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ONE   = 2'd1,
    ST_ONE0  = 2'd2,
    ST_HIT   = 2'd3
  } det_state_e;

endpackage

// File: rtl/pat101_rst_sync.sv
module pat101_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_sync_o
);

  logic [SYNC_STAGES-1:0] chain_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync_o = chain_q[SYNC_STAGES-1];

  // R6: the synchronised reset is low whenever the raw reset was low at the previous edge
  p_sync_follows_r6: assert property (@(posedge clk_i)
    !rst_n_i |=> !rst_n_sync_o);

endmodule

// File: rtl/pat101_next_state.sv
module pat101_next_state
  import pat101_pkg::*;
(
  input  det_state_e state_i,
  input  logic       bit_i,
  input  logic       overlap_i,
  input  logic       moore_sel_i,
  output det_state_e state_nxt_o
);

  det_state_e after_match;

  // Where a completed match leaves the machine in Mealy style.
  always_comb begin
    after_match = overlap_i ? ST_ONE : ST_IDLE;
  end

  always_comb begin
    state_nxt_o = ST_IDLE;
    unique case (state_i)
      ST_IDLE: state_nxt_o = bit_i ? ST_ONE : ST_IDLE;
      ST_ONE:  state_nxt_o = bit_i ? ST_ONE : ST_ONE0;
      ST_ONE0: begin
        if (!bit_i)          state_nxt_o = ST_IDLE;
        else if (moore_sel_i) state_nxt_o = ST_HIT;
        else                 state_nxt_o = after_match;
      end
      ST_HIT: begin
        // The last sampled bit was the closing 1 of a match.
        if (!moore_sel_i)    state_nxt_o = ST_IDLE;
        else if (bit_i)      state_nxt_o = ST_ONE;
        else if (overlap_i)  state_nxt_o = ST_ONE0;
        else                 state_nxt_o = ST_IDLE;
      end
      default: state_nxt_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pat101_state_reg.sv
module pat101_state_reg
  import pat101_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       moore_sel_i,
  input  det_state_e state_nxt_i,
  output det_state_e state_o
);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) state_o <= ST_IDLE;
    else          state_o <= state_nxt_i;
  end

  // R6: held idle while the synchronised reset is low
  p_reset_idle_r6: assert property (@(posedge clk_i)
    !rst_n_i |-> state_o == ST_IDLE);

  // R2: in Mealy style the dedicated hit state is never entered
  p_no_hit_state_mealy_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !moore_sel_i |-> state_o != ST_HIT);

endmodule

// File: rtl/pat101_out_dec.sv
module pat101_out_dec
  import pat101_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  det_state_e state_i,
  input  logic       bit_i,
  input  logic       moore_sel_i,
  output logic       hit_o
);

  logic mealy_hit;
  logic moore_hit;

  always_comb begin
    mealy_hit = (state_i == ST_ONE0) && bit_i;
    moore_hit = (state_i == ST_HIT);
    hit_o     = moore_sel_i ? moore_hit : mealy_hit;
  end

  // R1: a flag is never followed directly by another flag
  p_single_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hit_o |=> !hit_o);

  // R2: a Mealy flag needs a 1 on the input in the same cycle
  p_mealy_needs_one_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!moore_sel_i && hit_o) |-> bit_i);

  // R3: a Moore flag follows a sampled 1 that came after a sampled 0
  p_moore_after_one_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (moore_sel_i && hit_o) |-> ($past(bit_i) && $past(state_i) == ST_ONE0));

endmodule

// File: rtl/pat101_detector.sv
module pat101_detector
  import pat101_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic bit_i,
  input  logic overlap_i,
  input  logic moore_sel_i,
  output logic hit_o
);

  logic       rst_n_sync;
  det_state_e state_q;
  det_state_e state_nxt;

  pat101_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_n_sync_o (rst_n_sync)
  );

  pat101_next_state u_next (
    .state_i     (state_q),
    .bit_i       (bit_i),
    .overlap_i   (overlap_i),
    .moore_sel_i (moore_sel_i),
    .state_nxt_o (state_nxt)
  );

  pat101_state_reg u_state (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_sync),
    .moore_sel_i (moore_sel_i),
    .state_nxt_i (state_nxt),
    .state_o     (state_q)
  );

  pat101_out_dec u_out (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_sync),
    .state_i     (state_q),
    .bit_i       (bit_i),
    .moore_sel_i (moore_sel_i),
    .hit_o       (hit_o)
  );

  // R6: no flag while the raw reset is low
  p_no_flag_in_reset_r6: assert property (@(posedge clk_i)
    !rst_n_i |-> !hit_o);

endmodule

// File: tb/pat101_detector_tb_top.sv
`timescale 1ns/1ps
module pat101_detector_tb_top;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic ovl;
  logic moore;
  logic hit;

  int   n_checks = 0;
  int   n_errors = 0;
  longint cyc = 0;

  bit     q_exp[$];
  longint q_due[$];
  string  q_tag[$];

  logic [2:0] win;
  int         since;

  pat101_detector #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .bit_i       (din),
    .overlap_i   (ovl),
    .moore_sel_i (moore),
    .hit_o       (hit)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b (ovl=%b moore=%b)",
               tag, cyc, act, exp, ovl, moore);
    end
  endtask

  // Monitor: sample 1 ns before each rising edge, pop entries due this cycle.
  always @(negedge clk) begin
    #4;
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      check(hit, q_exp[0], q_tag[0]);
      void'(q_exp.pop_front());
      void'(q_due.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // Sliding-window reference with a spacing counter for non-overlap.
  task automatic model_step(input bit b, output bit e);
    win = {win[1:0], b};
    if (since < 1000) since++;
    e = (win == 3'b101) && (ovl || since >= 3);
    if (e && !ovl) since = 0;
  endtask

  task automatic send_bit(input bit b, input bit use_exp, input bit exp_in, input string tag);
    bit e;
    @(negedge clk);
    din = b;
    model_step(b, e);
    if (use_exp) e = exp_in;
    q_exp.push_back(e);
    q_due.push_back(moore ? cyc + 1 : cyc);
    q_tag.push_back(tag);
  endtask

  task automatic run_str(input string s, input string exp_s, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      send_bit(s[i] == "1", exp_s.len() > 0, exp_s.len() > 0 && exp_s[i] == "1", tag);
    end
  endtask

  task automatic flush();
    repeat (2) begin
      @(negedge clk);
      din = 1'b0;
    end
    while (q_due.size() > 0) @(negedge clk);
  endtask

  task automatic apply_reset(input bit o, input bit m);
    @(negedge clk);
    rst_n = 1'b0;
    ovl   = o;
    moore = m;
    din   = 1'b1;
    win   = 3'b000;
    since = 0;
    repeat (2) @(negedge clk);
    #4 check(hit, 1'b0, "R6 flag low in reset");
    @(negedge clk);
    din   = 1'b0;
    rst_n = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    #4 check(hit, 1'b0, "R6 idle after release");
  endtask

  initial begin
    rst_n = 1'b0;
    din   = 1'b0;
    ovl   = 1'b1;
    moore = 1'b0;
    win   = 3'b000;
    since = 0;
    for (int mode = 0; mode < 4; mode++) begin
      bit o = mode[0];
      bit m = mode[1];
      apply_reset(o, m);
      if (o) run_str("0110101011001", "0000101010000", m ? "R4 R3" : "R4 R2");
      else   run_str("0110101011001", "0000100010000", m ? "R5 R3" : "R5 R2");
      flush();
      apply_reset(o, m);
      run_str("1101", "0001", "R7");
      run_str("000", "", "R7 tail");
      flush();
      apply_reset(o, m);
      run_str("1001", "0000", "R8");
      run_str("000", "", "R8 tail");
      flush();
      apply_reset(o, m);
      for (int i = 0; i < 300; i++) begin
        send_bit(($urandom() % 3) != 0 ? ($urandom() % 2 == 1) : 1'b0, 1'b0, 1'b0, "R1 random");
      end
      flush();
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule